// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block runs the memory-access part of a small 16-bit processor. It handles the seven instructions that read memory, write memory or form a memory address. The caller presents the instruction word together with the already-incremented program counter, the value of the base register and the value of the store-source register, and pulses `start`. The sequencer works out the effective address in one of three ways: PC-relative with a 9-bit offset, base register plus a 6-bit offset, or indirect through a pointer held in memory. It then drives a single synchronous memory port. It finishes with a one-cycle `done` pulse. For loads and for address formation, that pulse comes with a register writeback and updated sign flags.

The memory port returns read data one clock after a read request. The sequencer keeps the address steady until it captures that data. Indirect forms make two accesses in turn. The first reads the operand's address and the second reads or writes the operand itself. The address-formation instruction touches no memory. A start with any other opcode, and any start while an instruction is in flight, is ignored.

Top module: `ldst_sequencer`

## Requirements
- R1: `start` is accepted only while `busy` is low and only for opcodes (instr[15:12]) 0010, 0011, 0110, 0111, 1010, 1011 and 1110. Any other opcode, or a start while busy, produces no `done`, no memory access and no writeback, and leaves `busy` low or unchanged.
- R2: Opcode 0010 (load) and 0011 (store) use address `npc` + sign-extended instr[8:0], wrapping at 16 bits.
- R3: Opcode 0110 (load) and 0111 (store) use address `base_val` + sign-extended instr[5:0], wrapping at 16 bits.
- R4: Opcode 1010 (load) and 1011 (store) first read the pointer at `npc` + sign-extended instr[8:0]. They then access the 16-bit address returned by that read. A load makes exactly two reads. A store makes one read and one write.
- R5: Opcode 1110 writes `npc` + sign-extended instr[8:0] to the destination register and asserts neither `mem_re` nor `mem_we`.
- R6: Loads and opcode 1110 assert `wb_en` with `done`. They put instr[11:9] on `wb_idx` and the loaded or computed value on `wb_data`. Stores write `src_val` to memory and assert no `wb_en`.
- R7: `nzp` is {N,Z,P} at bits 2,1,0. Exactly one bit is set. With `flags_we`, it takes the sign of the written value (bit 15 set gives N, zero gives Z, otherwise P) for every load and opcode 1110.
- R8: Stores leave `nzp` unchanged and keep `flags_we` low.
- R9: Read data is taken one cycle after `mem_re`. `mem_addr` stays stable in the cycle after `mem_re`. `mem_re` and `mem_we` are never high together.
- R10: `done` is a single-cycle pulse. Counting clock edges from the edge that accepts `start`, it rises after 2 edges for opcode 1110, 4 for 0010/0110, 3 for 0011/0111, 6 for 1010 and 5 for 1011.
- R11: After reset, `busy`, `done`, `mem_re`, `mem_we`, `wb_en` and `flags_we` are low and `nzp` is 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the instruction on `instr` |
| instr | input | 16 | Instruction word |
| npc | input | DATA_W | Incremented program counter |
| base_val | input | DATA_W | Base register value (instr[8:6] register) |
| src_val | input | DATA_W | Store-source register value (instr[11:9] register) |
| busy | output | 1 | Instruction in flight |
| mem_addr | output | DATA_W | Memory address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_re` |
| done | output | 1 | Instruction finished (one cycle) |
| wb_en | output | 1 | Register writeback strobe |
| wb_idx | output | IDX_W | Destination register index |
| wb_data | output | DATA_W | Writeback value |
| flags_we | output | 1 | Flags updated this cycle |
| nzp | output | 3 | Sign flags {N,Z,P} |

## Verification
The bench builds the block with its defaults: a 16-bit data path, 9-bit and 6-bit offsets, and 3-bit register indices. At these widths, the most negative offsets, the wrap of the address sum past 16'hFFFF and all three flag outcomes can each be reached with a single instruction. The bench memory returns a byte-swapped, masked copy of the address. An indirect access therefore lands at an address the bench can predict but that differs from the pointer address. This exposes mixed-up pointer and data phases.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;

  localparam logic [OPC_W-1:0] OPC_LD  = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_ST  = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
  localparam logic [OPC_W-1:0] OPC_STR = 4'b0111;
  localparam logic [OPC_W-1:0] OPC_LDI = 4'b1010;
  localparam logic [OPC_W-1:0] OPC_STI = 4'b1011;
  localparam logic [OPC_W-1:0] OPC_LEA = 4'b1110;

  typedef enum logic [1:0] {
    AM_PCREL,
    AM_BASE,
    AM_INDIR,
    AM_LEA
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_DONE
  } state_e;

  localparam logic [2:0] NZP_RESET = 3'b010;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 3,
  parameter int PC_OFS_W   = 9,
  parameter int BASE_OFS_W = 6
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               valid,
  output logic               is_store,
  output amode_e             mode,
  output logic [IDX_W-1:0]   reg_idx,
  output logic [DATA_W-1:0]  ofs
);

  localparam int OPC_LSB  = INSTR_W - OPC_W;
  localparam int IDX_MSB  = OPC_LSB - 1;
  localparam int PC_PAD   = DATA_W - PC_OFS_W;
  localparam int BASE_PAD = DATA_W - BASE_OFS_W;

  logic [OPC_W-1:0]  opc;
  logic [DATA_W-1:0] ofs_long;
  logic [DATA_W-1:0] ofs_short;

  assign opc       = instr[INSTR_W-1:OPC_LSB];
  assign reg_idx   = instr[IDX_MSB -: IDX_W];
  assign ofs_long  = {{PC_PAD{instr[PC_OFS_W-1]}}, instr[PC_OFS_W-1:0]};
  assign ofs_short = {{BASE_PAD{instr[BASE_OFS_W-1]}}, instr[BASE_OFS_W-1:0]};

  always_comb begin
    valid    = 1'b1;
    is_store = 1'b0;
    mode     = AM_PCREL;
    case (opc)
      OPC_LD:  mode = AM_PCREL;
      OPC_ST:  begin mode = AM_PCREL; is_store = 1'b1; end
      OPC_LDR: mode = AM_BASE;
      OPC_STR: begin mode = AM_BASE;  is_store = 1'b1; end
      OPC_LDI: mode = AM_INDIR;
      OPC_STI: begin mode = AM_INDIR; is_store = 1'b1; end
      OPC_LEA: mode = AM_LEA;
      default: valid = 1'b0;
    endcase
  end

  assign ofs = (mode == AM_BASE) ? ofs_short : ofs_long;

endmodule

// File: rtl/ldst_addr.sv
module ldst_addr
  import ldst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  amode_e            mode,
  input  logic [DATA_W-1:0] npc,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] ofs,
  output logic [DATA_W-1:0] ea
);

  logic [DATA_W-1:0] anchor;

  always_comb begin
    if (mode == AM_BASE) anchor = base;
    else                 anchor = npc;
  end

  assign ea = anchor + ofs;

endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dec_valid,
  input  logic              dec_store,
  input  amode_e            dec_mode,
  input  logic [IDX_W-1:0]  dec_idx,
  input  logic [DATA_W-1:0] dec_ofs,
  input  logic [DATA_W-1:0] npc,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] ea,
  input  logic [DATA_W-1:0] mem_rdata,
  output amode_e            mode_q,
  output logic [DATA_W-1:0] npc_q,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] ofs_q,
  output logic [IDX_W-1:0]  dst_q,
  output logic              busy,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              fin,
  output logic              fin_wb,
  output logic [DATA_W-1:0] fin_val
);

  state_e            state;
  logic              store_q;
  logic              pend;
  logic [DATA_W-1:0] src_q;
  logic              accept;

  assign accept = (state == ST_IDLE) && start && dec_valid;

  always_comb begin
    fin     = 1'b0;
    fin_wb  = !store_q;
    fin_val = mem_rdata;
    case (state)
      ST_ADDR: if (mode_q == AM_LEA) begin
        fin     = 1'b1;
        fin_val = ea;
      end
      ST_DATA: fin = store_q || pend;
      default: fin = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      pend      <= 1'b0;
      store_q   <= 1'b0;
      mode_q    <= AM_PCREL;
      npc_q     <= '0;
      base_q    <= '0;
      ofs_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
    end else begin
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_ADDR;
            busy    <= 1'b1;
            store_q <= dec_store;
            mode_q  <= dec_mode;
            npc_q   <= npc;
            base_q  <= base_val;
            ofs_q   <= dec_ofs;
            src_q   <= src_val;
            dst_q   <= dec_idx;
          end
        end
        ST_ADDR: begin
          pend <= 1'b0;
          case (mode_q)
            AM_LEA: state <= ST_DONE;
            AM_INDIR: begin
              mem_addr <= ea;
              mem_re   <= 1'b1;
              state    <= ST_PTR;
            end
            default: begin
              mem_addr <= ea;
              if (store_q) begin
                mem_we    <= 1'b1;
                mem_wdata <= src_q;
              end else begin
                mem_re <= 1'b1;
              end
              state <= ST_DATA;
            end
          endcase
        end
        ST_PTR: begin
          if (!pend) begin
            pend <= 1'b1;
          end else begin
            pend     <= 1'b0;
            mem_addr <= mem_rdata;
            if (store_q) begin
              mem_we    <= 1'b1;
              mem_wdata <= src_q;
            end else begin
              mem_re <= 1'b1;
            end
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (store_q || pend) begin
            pend  <= 1'b0;
            state <= ST_DONE;
          end else begin
            pend <= 1'b1;
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ldst_result.sv
module ldst_result
  import ldst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin,
  input  logic              fin_wb,
  input  logic [DATA_W-1:0] fin_val,
  input  logic [IDX_W-1:0]  dst,
  output logic              done,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              flags_we,
  output logic [2:0]        nzp
);

  logic [2:0] sign_of;

  always_comb begin
    if (fin_val[DATA_W-1])   sign_of = 3'b100;
    else if (fin_val == '0)  sign_of = 3'b010;
    else                     sign_of = 3'b001;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      wb_en    <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      flags_we <= 1'b0;
      nzp      <= NZP_RESET;
    end else begin
      done     <= fin;
      wb_en    <= fin && fin_wb;
      flags_we <= fin && fin_wb;
      if (fin && fin_wb) begin
        wb_idx  <= dst;
        wb_data <= fin_val;
        nzp     <= sign_of;
      end
    end
  end

endmodule

// File: rtl/ldst_sequencer.sv
module ldst_sequencer
  import ldst_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 3,
  parameter int PC_OFS_W   = 9,
  parameter int BASE_OFS_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  npc,
  input  logic [DATA_W-1:0]  base_val,
  input  logic [DATA_W-1:0]  src_val,
  output logic               busy,
  output logic [DATA_W-1:0]  mem_addr,
  output logic               mem_re,
  output logic               mem_we,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               done,
  output logic               wb_en,
  output logic [IDX_W-1:0]   wb_idx,
  output logic [DATA_W-1:0]  wb_data,
  output logic               flags_we,
  output logic [2:0]         nzp
);

  logic              dec_valid;
  logic              dec_store;
  amode_e            dec_mode;
  logic [IDX_W-1:0]  dec_idx;
  logic [DATA_W-1:0] dec_ofs;
  amode_e            mode_q;
  logic [DATA_W-1:0] npc_q;
  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] ofs_q;
  logic [IDX_W-1:0]  dst_q;
  logic [DATA_W-1:0] ea;
  logic              fin;
  logic              fin_wb;
  logic [DATA_W-1:0] fin_val;

  ldst_decode #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .PC_OFS_W(PC_OFS_W), .BASE_OFS_W(BASE_OFS_W)
  ) u_decode (
    .instr(instr), .valid(dec_valid), .is_store(dec_store), .mode(dec_mode),
    .reg_idx(dec_idx), .ofs(dec_ofs)
  );

  ldst_addr #(.DATA_W(DATA_W)) u_addr (
    .mode(mode_q), .npc(npc_q), .base(base_q), .ofs(ofs_q), .ea(ea)
  );

  ldst_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .dec_valid(dec_valid), .dec_store(dec_store), .dec_mode(dec_mode),
    .dec_idx(dec_idx), .dec_ofs(dec_ofs),
    .npc(npc), .base_val(base_val), .src_val(src_val), .ea(ea), .mem_rdata(mem_rdata),
    .mode_q(mode_q), .npc_q(npc_q), .base_q(base_q), .ofs_q(ofs_q), .dst_q(dst_q),
    .busy(busy), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .fin(fin), .fin_wb(fin_wb), .fin_val(fin_val)
  );

  ldst_result #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_result (
    .clk(clk), .rst(rst), .fin(fin), .fin_wb(fin_wb), .fin_val(fin_val), .dst(dst_q),
    .done(done), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .flags_we(flags_we), .nzp(nzp)
  );

endmodule

// File: rtl/ldst_checker.sv
module ldst_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic [DATA_W-1:0] mem_addr,
  input logic              mem_re,
  input logic              mem_we,
  input logic              done,
  input logic              wb_en,
  input logic              flags_we,
  input logic [2:0]        nzp
);

  a_r9_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> $stable(mem_addr));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r1_done_inside_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  a_r6_wb_only_at_done: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);

  a_r8_flags_need_wb: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> wb_en);

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !flags_we |-> $stable(nzp));

  a_r7_onehot_flags: assert property (@(posedge clk) disable iff (rst)
    $countones(nzp) == 1);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_re || mem_we));

endmodule

bind ldst_sequencer ldst_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mem_addr(mem_addr), .mem_re(mem_re),
  .mem_we(mem_we), .done(done), .wb_en(wb_en), .flags_we(flags_we), .nzp(nzp)
);

// File: tb/ldst_sequencer_bench.sv
`timescale 1ns/1ps
module ldst_sequencer_bench;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [15:0]   instr = '0;
  logic [DW-1:0] npc = '0, base_val = '0, src_val = '0;
  logic          busy, mem_re, mem_we, done, wb_en, flags_we;
  logic [DW-1:0] mem_addr, mem_wdata, wb_data;
  logic [DW-1:0] mem_rdata = '0;
  logic [2:0]    wb_idx, nzp;

  int n_checks = 0;
  int n_fails  = 0;
  int re_tot = 0, we_tot = 0, done_tot = 0;
  logic [DW-1:0] rd_addr_log [0:1];
  logic [DW-1:0] wr_addr_last = '0, wr_data_last = '0;

  always #10 clk = ~clk;

  ldst_sequencer u_ldst_sequencer (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .npc(npc),
    .base_val(base_val), .src_val(src_val), .busy(busy), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .flags_we(flags_we), .nzp(nzp)
  );

  function automatic logic [DW-1:0] memfn(input logic [DW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  function automatic logic [DW-1:0] sx9(input logic [15:0] i);
    return {{7{i[8]}}, i[8:0]};
  endfunction

  function automatic logic [DW-1:0] sx6(input logic [15:0] i);
    return {{10{i[5]}}, i[5:0]};
  endfunction

  function automatic logic [2:0] sgn(input logic [DW-1:0] v);
    if (v[15]) return 3'b100;
    if (v == '0) return 3'b010;
    return 3'b001;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= memfn(mem_addr);

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_re) begin
        if (re_tot % 2 == 0) rd_addr_log[0] <= mem_addr;
        else                 rd_addr_log[1] <= mem_addr;
        re_tot <= re_tot + 1;
      end
      if (mem_we) begin
        we_tot <= we_tot + 1;
        wr_addr_last <= mem_addr;
        wr_data_last <= mem_wdata;
      end
      if (done) done_tot <= done_tot + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] ins, input logic [DW-1:0] pc,
                     input logic [DW-1:0] b, input logic [DW-1:0] s, output int edges);
    @(negedge clk);
    instr = ins; npc = pc; base_val = b; src_val = s; start = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && edges < 40) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(!busy && !done && !mem_re && !mem_we && !wb_en && !flags_we, "R11",
        "quiet outputs", {busy, done, mem_re, mem_we, wb_en, flags_we}, 0);
    chk(nzp == 3'b010, "R11", "nzp", nzp, 3'b010);
  endtask

  task automatic t_load(input string req, input logic [15:0] ins, input logic [DW-1:0] pc,
                        input logic [DW-1:0] b, input logic [DW-1:0] ea, input int lat);
    int e, r0;
    logic [DW-1:0] expv;
    r0 = re_tot;
    expv = memfn(ea);
    run(ins, pc, b, 16'hDEAD, e);
    chk(e == lat, "R10", {req, " latency"}, e, lat);
    chk(wb_en && wb_data == expv, req, "load value", wb_data, expv);
    chk(wb_idx == ins[11:9], "R6", "wb_idx", wb_idx, ins[11:9]);
    chk(flags_we && nzp == sgn(expv), "R7", "flags", nzp, sgn(expv));
    #1;
    chk(re_tot - r0 == 1 && rd_addr_log[r0 % 2] == ea, req, "read address",
        rd_addr_log[r0 % 2], ea);
  endtask

  task automatic t_store(input string req, input logic [15:0] ins, input logic [DW-1:0] pc,
                         input logic [DW-1:0] b, input logic [DW-1:0] s,
                         input logic [DW-1:0] ea, input int lat, input int nreads);
    int e, r0, w0;
    logic [2:0] f0;
    r0 = re_tot; w0 = we_tot; f0 = nzp;
    run(ins, pc, b, s, e);
    chk(e == lat, "R10", {req, " latency"}, e, lat);
    chk(!wb_en, "R6", "store no writeback", wb_en, 0);
    chk(!flags_we && nzp == f0, "R8", "flags kept", nzp, f0);
    #1;
    chk(we_tot - w0 == 1 && re_tot - r0 == nreads, req, "access counts",
        (we_tot - w0) * 16 + (re_tot - r0), 16 + nreads);
    chk(wr_addr_last == ea, req, "write address", wr_addr_last, ea);
    chk(wr_data_last == s, "R6", "write data", wr_data_last, s);
  endtask

  task automatic t_ld_pcrel;
    t_load("R2", {4'b0010, 3'd5, 9'h010}, 16'h3000, 16'h0, 16'h3010, 4);
    t_load("R2", {4'b0010, 3'd1, 9'h03C}, 16'h5A00, 16'h0, 16'h5A3C, 4);
    t_load("R2", {4'b0010, 3'd2, 9'h100}, 16'h0080, 16'h0, 16'hFF80, 4);
  endtask

  task automatic t_ldr;
    t_load("R3", {4'b0110, 3'd3, 3'd0, 6'h20}, 16'h1111, 16'h1290, 16'h1270, 4);
    t_load("R3", {4'b0110, 3'd7, 3'd4, 6'h3F}, 16'h1111, 16'h12A0, 16'h129F, 4);
  endtask

  task automatic t_ldi;
    int e, r0;
    logic [15:0] ins;
    logic [DW-1:0] ptr, ea, expv;
    ins = {4'b1010, 3'd6, 9'h1FE};
    ptr = 16'h2000 + sx9(ins);
    ea = memfn(ptr);
    expv = memfn(ea);
    r0 = re_tot;
    run(ins, 16'h2000, 16'h0, 16'h0, e);
    chk(e == 6, "R10", "LDI latency", e, 6);
    chk(wb_en && wb_data == expv && wb_idx == 3'd6, "R4", "indirect load value", wb_data, expv);
    chk(nzp == sgn(expv), "R7", "indirect flags", nzp, sgn(expv));
    #1;
    chk(re_tot - r0 == 2, "R4", "two reads", re_tot - r0, 2);
    chk(rd_addr_log[r0 % 2] == ptr, "R4", "pointer address", rd_addr_log[r0 % 2], ptr);
    chk(rd_addr_log[(r0 + 1) % 2] == ea, "R4", "operand address",
        rd_addr_log[(r0 + 1) % 2], ea);
  endtask

  task automatic t_stores;
    logic [15:0] ins;
    ins = {4'b0011, 3'd2, 9'h1F0};
    t_store("R2", ins, 16'h4000, 16'h0, 16'hBEEF, 16'h4000 + sx9(ins), 3, 0);
    ins = {4'b0111, 3'd4, 3'd1, 6'h1F};
    t_store("R3", ins, 16'h0, 16'hFFF0, 16'h0000, 16'hFFF0 + sx6(ins), 3, 0);
    ins = {4'b1011, 3'd0, 9'h022};
    t_store("R4", ins, 16'h0700, 16'h0, 16'h8001, memfn(16'h0722), 5, 1);
  endtask

  task automatic t_lea;
    int e, r0, w0;
    logic [15:0] ins;
    logic [DW-1:0] expv;
    ins = {4'b1110, 3'd4, 9'h1F0};
    expv = 16'h0005 + sx9(ins);
    r0 = re_tot; w0 = we_tot;
    run(ins, 16'h0005, 16'h1234, 16'h0, e);
    chk(e == 2, "R10", "LEA latency", e, 2);
    chk(wb_en && wb_data == expv && wb_idx == 3'd4, "R5", "LEA value", wb_data, expv);
    chk(flags_we && nzp == 3'b100, "R7", "LEA flags negative", nzp, 3'b100);
    #1;
    chk(re_tot == r0 && we_tot == w0, "R5", "no memory access",
        (re_tot - r0) + (we_tot - w0), 0);
  endtask

  task automatic t_ignore_opcode;
    int d0, r0, w0;
    bit seen;
    d0 = done_tot; r0 = re_tot; w0 = we_tot; seen = 1'b0;
    @(negedge clk);
    instr = {4'b0001, 12'h123}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || wb_en) seen = 1'b1;
    end
    chk(!seen, "R1", "non-memory opcode busy/wb", seen, 0);
    chk(done_tot == d0 && re_tot == r0 && we_tot == w0, "R1", "non-memory opcode activity",
        (done_tot - d0) + (re_tot - r0) + (we_tot - w0), 0);
  endtask

  task automatic t_start_while_busy;
    int d0;
    logic [15:0] ins;
    logic [DW-1:0] expv;
    ins = {4'b1010, 3'd2, 9'h005};
    expv = memfn(memfn(16'h3300 + sx9(ins)));
    d0 = done_tot;
    @(negedge clk);
    instr = ins; npc = 16'h3300; start = 1'b1;
    @(negedge clk);
    instr = {4'b1110, 3'd7, 9'h001}; npc = 16'h0100;
    for (int i = 0; i < 3; i++) @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    chk(done && wb_idx == 3'd2 && wb_data == expv, "R1", "busy start ignored", wb_data, expv);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk(done_tot - d0 == 1 && !busy, "R1", "single completion", done_tot - d0, 1);
  endtask

  initial begin
    #(20 * 150000);
    n_fails++;
    $display("FAIL R10 watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ld_pcrel();
    t_ldr();
    t_ldi();
    t_stores();
    t_lea();
    t_ignore_opcode();
    t_start_while_busy();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule